// File: doc/BRIEF.md
# Limb-Serial Wide Integer Multiplier

This block multiplies two 135-bit unsigned integers with the schoolbook method. It uses five 27x27-bit multipliers, one for each 27-bit limb of the second operand. The first operand A arrives one limb per cycle, least significant limb first. The second operand B is presented as a full word and held for the five accepted limbs of a frame. B can be a second operand or a key word; the block treats both the same way. Each accepted A limb is multiplied by every limb of B in the same cycle. The five partial products are added into a bank of column accumulators, each wider than one limb. The lowest column is then retired as one output limb and the bank shifts down by one limb position.

The 270-bit product leaves the block on two serial channels. The low channel carries limbs 0 to 4, one cycle after each A limb is accepted. When the fifth limb of a frame is accepted, the remaining columns are handed to a drain unit. This unit propagates carries and emits limbs 5 to 9 on the high channel over the next five cycles. Meanwhile the accumulator is already taking the next frame. A new operand pair can therefore start every five cycles with no stall. Idle cycles, marked by a low valid input, pause a frame without losing it.

Top module: `limb_serial_mul`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, lo_valid_o and hi_valid_o are 0.
- R2: Limbs of A are numbered k = 0..4 within a frame, least significant first. In the cycle after limb k is accepted, lo_valid_o is 1 and lo_limb_o equals bits [27k+26:27k] of the product A*B.
- R3: Let E be the clock edge that accepts limb 4 of a frame. For m = 0..4, product bits [27(5+m)+26:27(5+m)] are on hi_limb_o with hi_valid_o = 1 in the cycle after the (m+1)-th clock edge following E. In all other cycles hi_valid_o is 0.
- R4: Frames sent back to back with no idle cycle are all multiplied correctly. This includes the edge where a new frame's upper columns are handed to the drain unit while the previous frame's last high limb is emitted.
- R5: A cycle with in_valid_i low is ignored. The frame position does not advance, lo_valid_o is 0 in the next cycle, and lo_limb_o keeps its value.
- R6: a_limb_i and b_word_i are sampled only at edges where in_valid_i is 1, and b_word_i keeps one value across the five accepted limbs of a frame. Values driven on them during idle cycles have no effect on any product.
- R7: Operands of all ones give exactly (2^135-1)^2 with no loss in the column accumulators.
- R8: Each frame yields exactly five valid low limbs and five valid high limbs, and no others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Qualifies a_limb_i for this cycle |
| a_limb_i | input | 27 | Next limb of operand A, least significant first |
| b_word_i | input | 135 | Operand B, held across the five accepted limbs of a frame |
| lo_valid_o | output | 1 | lo_limb_o carries a new product limb |
| lo_limb_o | output | 27 | Product limbs 0..4 of the current frame |
| hi_valid_o | output | 1 | hi_limb_o carries a new product limb |
| hi_limb_o | output | 27 | Product limbs 5..9 of the previous frame |

## Verification
Two functions can fall on the same edge. One is the hand-off of a new frame's upper columns into the drain unit. The other is the drain unit's final step for the previous frame. Back-to-back frames cause this on every frame, and idle cycles inserted at random limb positions move the hand-off away from the drain steps. Every limb on both channels is compared with a 270-bit product computed in the bench. The valid flags are compared cycle by cycle against a schedule derived from R2, R3 and R5.

// File: rtl/limb_serial_mul_pkg.sv
package limb_serial_mul_pkg;
  localparam int unsigned LIMB_W_DEF  = 27;
  localparam int unsigned N_LIMBS_DEF = 5;
endpackage

// File: rtl/lsm_limb_ctr.sv
module lsm_limb_ctr #(
  parameter int unsigned N_LIMBS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic first_o,
  output logic last_o
);
  localparam int unsigned IW = (N_LIMBS > 1) ? $clog2(N_LIMBS) : 1;

  logic [IW-1:0] idx_q;

  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == IW'(N_LIMBS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (step_i) idx_q <= last_o ? '0 : idx_q + IW'(1);
  end
endmodule

// File: rtl/lsm_mac_row.sv
module lsm_mac_row #(
  parameter int unsigned LIMB_W  = 27,
  parameter int unsigned N_LIMBS = 5,
  parameter int unsigned ACC_W   = 59
) (
  input  logic [LIMB_W-1:0]               a_i,
  input  logic [N_LIMBS*LIMB_W-1:0]       b_i,
  input  logic                            clear_i,
  input  logic [N_LIMBS-1:0][ACC_W-1:0]   cols_i,
  output logic [N_LIMBS-1:0][ACC_W-1:0]   cols_o
);
  localparam int unsigned PW = 2 * LIMB_W;

  for (genvar j = 0; j < N_LIMBS; j++) begin : g_mul
    logic [PW-1:0]    a_ext, b_ext, prod;
    logic [ACC_W-1:0] base;
    assign a_ext = PW'(a_i);
    assign b_ext = PW'(b_i[j*LIMB_W +: LIMB_W]);
    assign prod  = a_ext * b_ext;
    assign base  = clear_i ? '0 : cols_i[j];
    assign cols_o[j] = base + ACC_W'(prod);
  end
endmodule

// File: rtl/lsm_col_shift.sv
module lsm_col_shift #(
  parameter int unsigned LIMB_W  = 27,
  parameter int unsigned N_LIMBS = 5,
  parameter int unsigned ACC_W   = 59
) (
  input  logic [N_LIMBS-1:0][ACC_W-1:0] cols_i,
  output logic [LIMB_W-1:0]             limb_o,
  output logic [N_LIMBS-1:0][ACC_W-1:0] cols_o
);
  assign limb_o = cols_i[0][LIMB_W-1:0];

  // retire column 0, pass its carry into the next column, shift down
  for (genvar j = 0; j < N_LIMBS; j++) begin : g_col
    if (j == N_LIMBS - 1) begin : g_top
      assign cols_o[j] = '0;
    end else if (j == 0) begin : g_low
      assign cols_o[j] = cols_i[1] + (cols_i[0] >> LIMB_W);
    end else begin : g_mid
      assign cols_o[j] = cols_i[j+1];
    end
  end
endmodule

// File: rtl/lsm_drain.sv
module lsm_drain #(
  parameter int unsigned LIMB_W  = 27,
  parameter int unsigned N_LIMBS = 5,
  parameter int unsigned ACC_W   = 59
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [N_LIMBS-1:0][ACC_W-1:0] cols_i,
  output logic                          valid_o,
  output logic [LIMB_W-1:0]             limb_o
);
  localparam int unsigned CW = $clog2(N_LIMBS + 1);

  logic [N_LIMBS-1:0][ACC_W-1:0] cols_q, cols_sh;
  logic [CW-1:0]                 left_q;
  logic [LIMB_W-1:0]             limb_d;
  logic                          busy;

  assign busy = (left_q != '0);

  lsm_col_shift #(.LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS), .ACC_W(ACC_W)) u_shift (
    .cols_i(cols_q),
    .limb_o(limb_d),
    .cols_o(cols_sh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cols_q  <= '0;
      left_q  <= '0;
      valid_o <= 1'b0;
      limb_o  <= '0;
    end else begin
      valid_o <= busy;
      if (busy) limb_o <= limb_d;
      // a load may land on the last step of the previous frame
      if (load_i) begin
        cols_q <= cols_i;
        left_q <= CW'(N_LIMBS);
      end else if (busy) begin
        cols_q <= cols_sh;
        left_q <= left_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/limb_serial_mul.sv
module limb_serial_mul
  import limb_serial_mul_pkg::*;
#(
  parameter int unsigned LIMB_W  = LIMB_W_DEF,
  parameter int unsigned N_LIMBS = N_LIMBS_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic [LIMB_W-1:0]         a_limb_i,
  input  logic [N_LIMBS*LIMB_W-1:0] b_word_i,
  output logic                      lo_valid_o,
  output logic [LIMB_W-1:0]         lo_limb_o,
  output logic                      hi_valid_o,
  output logic [LIMB_W-1:0]         hi_limb_o
);
  localparam int unsigned ACC_W = 2 * LIMB_W + $clog2(N_LIMBS) + 2;

  logic [N_LIMBS-1:0][ACC_W-1:0] acc_q, sum_cols, sh_cols;
  logic [LIMB_W-1:0]             lo_d;
  logic                          first, last;

  lsm_limb_ctr #(.N_LIMBS(N_LIMBS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (in_valid_i),
    .first_o(first),
    .last_o (last)
  );

  lsm_mac_row #(.LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS), .ACC_W(ACC_W)) u_mac (
    .a_i    (a_limb_i),
    .b_i    (b_word_i),
    .clear_i(first),
    .cols_i (acc_q),
    .cols_o (sum_cols)
  );

  lsm_col_shift #(.LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS), .ACC_W(ACC_W)) u_shift (
    .cols_i(sum_cols),
    .limb_o(lo_d),
    .cols_o(sh_cols)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      lo_valid_o <= 1'b0;
      lo_limb_o  <= '0;
    end else begin
      lo_valid_o <= in_valid_i;
      if (in_valid_i) begin
        acc_q     <= sh_cols;
        lo_limb_o <= lo_d;
      end
    end
  end

  lsm_drain #(.LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS), .ACC_W(ACC_W)) u_drain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (in_valid_i & last),
    .cols_i (sh_cols),
    .valid_o(hi_valid_o),
    .limb_o (hi_limb_o)
  );
endmodule

// File: rtl/limb_serial_mul_chk.sv
module limb_serial_mul_chk #(
  parameter int unsigned LIMB_W  = 27,
  parameter int unsigned N_LIMBS = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              lo_valid_o,
  input logic [LIMB_W-1:0] lo_limb_o,
  input logic              hi_valid_o
);
  localparam int unsigned IW = (N_LIMBS > 1) ? $clog2(N_LIMBS) : 1;
  localparam int unsigned CW = $clog2(N_LIMBS + 1);

  logic [IW-1:0] seen_q;
  logic [CW-1:0] owe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      owe_q  <= '0;
    end else begin
      if (in_valid_i) seen_q <= (seen_q == IW'(N_LIMBS - 1)) ? '0 : seen_q + IW'(1);
      if (in_valid_i && seen_q == IW'(N_LIMBS - 1)) owe_q <= CW'(N_LIMBS);
      else if (owe_q != '0)                          owe_q <= owe_q - CW'(1);
    end
  end

  // R2
  a_r2_lo_follows_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_valid_o |-> $past(in_valid_i));
  // R5
  a_r5_idle_no_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !lo_valid_o);
  // R5
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(lo_limb_o));
  // R3
  a_r3_hi_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_valid_o == $past(owe_q != '0));
endmodule

bind limb_serial_mul limb_serial_mul_chk #(.LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .lo_valid_o(lo_valid_o),
  .lo_limb_o (lo_limb_o),
  .hi_valid_o(hi_valid_o)
);

// File: tb/limb_serial_mul_tb_top.sv
module limb_serial_mul_tb_top;
  localparam int W   = 27;
  localparam int N   = 5;
  localparam int OPW = W * N;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   a_limb = '0;
  logic [OPW-1:0] b_word = '0;
  logic           lo_valid, hi_valid;
  logic [W-1:0]   lo_limb, hi_limb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string tag = "R1";

  logic [W-1:0] lo_q[$];
  logic [W-1:0] hi_q[$];

  always #10 clk = ~clk;

  limb_serial_mul dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid),
    .a_limb_i  (a_limb),
    .b_word_i  (b_word),
    .lo_valid_o(lo_valid),
    .lo_limb_o (lo_limb),
    .hi_valid_o(hi_valid),
    .hi_limb_o (hi_limb)
  );

  // expected valid schedule from R2/R3/R5
  int  pos = 0;
  int  owe = 0;
  bit  exp_lo_v = 1'b0;
  bit  exp_hi_v = 1'b0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pos <= 0; owe <= 0; exp_lo_v <= 1'b0; exp_hi_v <= 1'b0;
    end else begin
      exp_lo_v <= in_valid;
      exp_hi_v <= (owe != 0);
      if (in_valid) pos <= (pos == N - 1) ? 0 : pos + 1;
      if (in_valid && pos == N - 1) owe <= N;
      else if (owe != 0)            owe <= owe - 1;
    end
  end

  task automatic check_bit(input string t, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b", t, what, act, exp);
    end
  endtask

  task automatic check_limb(input string t, input string what, input logic [W-1:0] act,
                            input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      check_bit("R1", "lo_valid in reset", lo_valid, 1'b0);
      check_bit("R1", "hi_valid in reset", hi_valid, 1'b0);
    end else if (!done) begin
      check_bit("R2", "lo_valid schedule", lo_valid, exp_lo_v);
      check_bit("R3", "hi_valid schedule", hi_valid, exp_hi_v);
      if (lo_valid) begin
        if (lo_q.size() == 0) check_limb("R8", "extra lo limb", lo_limb, 'x);
        else check_limb(tag, "lo limb", lo_limb, lo_q.pop_front());
      end
      if (hi_valid) begin
        if (hi_q.size() == 0) check_limb("R8", "extra hi limb", hi_limb, 'x);
        else check_limb(tag, "hi limb", hi_limb, hi_q.pop_front());
      end
    end
  end

  function automatic logic [OPW-1:0] rnd_word();
    logic [159:0] t;
    t = {$urandom, $urandom, $urandom, $urandom, $urandom};
    return t[OPW-1:0];
  endfunction

  task automatic send_frame(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input int gaps);
    logic [2*OPW-1:0] p;
    p = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
    for (int k = 0; k < N; k++) begin
      lo_q.push_back(p[k*W +: W]);
      hi_q.push_back(p[(N+k)*W +: W]);
    end
    for (int i = 0; i < N; i++) begin
      if (gaps[i]) begin
        // R6: junk on the data inputs while idle
        in_valid = 1'b0;
        a_limb   = W'($urandom);
        b_word   = rnd_word();
        @(negedge clk);
      end
      in_valid = 1'b1;
      a_limb   = a[i*W +: W];
      b_word   = b;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [OPW-1:0] ones;
    ones = '1;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_bit("R1", "lo_valid after reset", lo_valid, 1'b0);
    check_bit("R1", "hi_valid after reset", hi_valid, 1'b0);

    // limb-position sweep, back to back
    tag = "R2";
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        logic [OPW-1:0] a, b;
        a = '0; b = '0;
        a[i*W +: W] = '1;
        b[j*W +: W] = '1;
        send_frame(a, b, 0);
      end

    tag = "R4";
    for (int f = 0; f < 40; f++) send_frame(rnd_word(), rnd_word(), 0);

    tag = "R7";
    send_frame(ones, ones, 0);
    send_frame(ones, ones, 0);
    send_frame(ones, '0, 0);
    send_frame(ones, OPW'(1), 0);
    send_frame(ones, ones, 0);

    tag = "R5";
    for (int f = 0; f < 30; f++) send_frame(rnd_word(), rnd_word(), int'($urandom_range(0, 31)));

    tag = "R6";
    for (int f = 0; f < 10; f++) send_frame(ones, rnd_word(), 5'b11111);
    send_frame(ones, ones, 5'b10101);

    in_valid = 1'b0;
    a_limb   = W'($urandom);
    b_word   = rnd_word();
    repeat (12) @(negedge clk);

    checks++;
    if (lo_q.size() != 0) begin
      failures++;
      $display("FAIL R8 lo limbs missing act=%0d exp=0", lo_q.size());
    end
    checks++;
    if (hi_q.size() != 0) begin
      failures++;
      $display("FAIL R8 hi limbs missing act=%0d exp=0", hi_q.size());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule